// File: doc/BRIEF.md
# Programmable Management Clock Divider

This block derives the slow management-interface clock (MDC) from the internal bus clock. Software writes a 32-bit control word. The word holds a 6-bit speed value N and a preamble-skip flag. While N is nonzero, MDC toggles every N bus cycles, so its frequency is the bus frequency divided by 2N and its duty cycle is 50%. When N is zero, MDC is stopped and held low. For example, N = 5 on a 25 MHz bus gives a 2.5 MHz MDC.

A frame engine sits beside the block. It uses two single-cycle strobes, one marking the bus cycle in which MDC goes high and one marking the cycle in which it goes low, to time its data bits. It also uses a running flag. The speed value is sampled only at the reload point of the half-period counter, which is the moment MDC toggles. Reprogramming therefore never shortens or stretches a phase that is already under way. No runt pulse can reach the pin.

Top module: `mdc_clkgen`

## Requirements
- R1: After a synchronous reset the control word reads 0x0000_0000, and MDC, both strobes, the running flag and the preamble-skip output are all low.
- R2: The readback returns the written speed in bits 6..1 and the preamble-skip flag in bit 7. Bit 0 and bits 31..8 always read zero, whatever was written there.
- R3: The preamble-skip output equals bit 7 of the last written control word.
- R4: While the speed field is zero and MDC is low, MDC stays low, neither strobe fires and the running flag is low.
- R5: For a nonzero speed N held constant, MDC is high for exactly N bus cycles and then low for exactly N bus cycles, for every N from 1 to 63.
- R6: The rise strobe is high for exactly the first bus cycle in which MDC is high. The fall strobe is high for exactly the first bus cycle in which MDC is low after a high phase. The two strobes are never high together.
- R7: A new nonzero speed written during a phase does not change that phase's length. It takes effect from the next MDC edge onwards.
- R8: When the speed is changed from nonzero to zero during a high phase, MDC completes that high phase at its old length, goes low with a fall strobe, and then stays low. The running flag drops in the same cycle as the fall.
- R9: From the stopped state, MDC first goes high in the bus cycle after the one in which the control word takes a nonzero speed.
- R10: The running flag is high whenever MDC is high, and it stays high through the low phases of a running clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control word write enable |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback |
| pre_skip | output | 1 | Preamble-skip flag for the frame engine |
| mdc | output | 1 | Management clock output |
| mdc_rise | output | 1 | One-cycle strobe on the cycle MDC goes high |
| mdc_fall | output | 1 | One-cycle strobe on the cycle MDC goes low |
| mdc_running | output | 1 | Clock-running flag |

## Verification
The bench builds the block with its default parameters: a 32-bit control word, with a 6-bit speed field at bit 1 and the skip flag at bit 7. With that layout, speeds of 1 (the shortest period, two bus cycles), 5 and 63 (the longest half period) can each be measured, along with the readback of reserved bits. It reprograms the speed in the middle of a high phase, both to a smaller nonzero value and to zero. This shows that phase lengths change only at an MDC edge, and that a stop always lets the high phase finish.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  // Level of the management clock output.
  typedef enum logic {
    MDC_LOW  = 1'b0,
    MDC_HIGH = 1'b1
  } mdc_level_e;

  // Reload value for a half period of N bus cycles; zero speed parks the counter.
  function automatic logic [5:0] half_reload(input logic [5:0] n);
    return (n == 6'd0) ? 6'd0 : n - 6'd1;
  endfunction
endpackage

// File: rtl/mdc_ctl_reg.sv
module mdc_ctl_reg #(
  parameter int DATA_W  = 32,
  parameter int SPD_W   = 6,
  parameter int SPD_LSB = 1,
  parameter int PRE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SPD_W-1:0]  spd,
  output logic              pre_skip,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SPD_MSB = SPD_LSB + SPD_W - 1;

  logic [SPD_W-1:0] spd_q;
  logic             pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      spd_q <= '0;
      pre_q <= 1'b0;
    end else if (wr_en) begin
      spd_q <= wr_data[SPD_MSB:SPD_LSB];
      pre_q <= wr_data[PRE_BIT];
    end
  end

  // Reserved positions are never stored, so they read back as zero.
  always_comb begin
    rd_data                  = '0;
    rd_data[SPD_MSB:SPD_LSB] = spd_q;
    rd_data[PRE_BIT]         = pre_q;
  end

  assign spd      = spd_q;
  assign pre_skip = pre_q;
endmodule

// File: rtl/mdc_halfcnt.sv
module mdc_halfcnt #(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SPD_W-1:0] spd,
  output logic             tick
);
  logic [SPD_W-1:0] cnt_q;
  logic [SPD_W-1:0] reload;

  // The speed is read only when the count reaches zero (an MDC toggle point).
  assign reload = (spd == '0) ? '0 : spd - SPD_W'(1);
  assign tick   = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= reload;
    else           cnt_q <= cnt_q - SPD_W'(1);
  end
endmodule

// File: rtl/mdc_phase.sv
module mdc_phase
  import mdc_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [SPD_W-1:0] spd,
  output logic             mdc,
  output logic             rise,
  output logic             fall,
  output logic             running
);
  mdc_level_e lvl_q;
  logic       rise_q, fall_q, run_q;
  logic       spd_zero;

  assign spd_zero = (spd == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= MDC_LOW;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (tick) begin
        if (lvl_q == MDC_HIGH) begin
          // A high phase always ends with a fall, even when stopping.
          lvl_q  <= MDC_LOW;
          fall_q <= 1'b1;
          if (spd_zero) run_q <= 1'b0;
        end else if (!spd_zero) begin
          lvl_q  <= MDC_HIGH;
          rise_q <= 1'b1;
          run_q  <= 1'b1;
        end else begin
          run_q <= 1'b0;
        end
      end
    end
  end

  assign mdc     = (lvl_q == MDC_HIGH);
  assign rise    = rise_q;
  assign fall    = fall_q;
  assign running = run_q;
endmodule

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
  parameter int DATA_W  = 32,
  parameter int SPD_W   = 6,
  parameter int SPD_LSB = 1,
  parameter int PRE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              pre_skip,
  output logic              mdc,
  output logic              mdc_rise,
  output logic              mdc_fall,
  output logic              mdc_running
);
  logic [SPD_W-1:0] spd;
  logic             tick;

  mdc_ctl_reg #(
    .DATA_W (DATA_W),
    .SPD_W  (SPD_W),
    .SPD_LSB(SPD_LSB),
    .PRE_BIT(PRE_BIT)
  ) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .spd     (spd),
    .pre_skip(pre_skip),
    .rd_data (rd_data)
  );

  mdc_halfcnt #(.SPD_W(SPD_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .spd (spd),
    .tick(tick)
  );

  mdc_phase #(.SPD_W(SPD_W)) u_ph (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .spd    (spd),
    .mdc    (mdc),
    .rise   (mdc_rise),
    .fall   (mdc_fall),
    .running(mdc_running)
  );
endmodule

// File: rtl/mdc_clkgen_chk.sv
module mdc_clkgen_chk #(
  parameter int DATA_W  = 32,
  parameter int SPD_W   = 6,
  parameter int SPD_LSB = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] rd_data,
  input logic              mdc,
  input logic              mdc_rise,
  input logic              mdc_fall,
  input logic              mdc_running
);
  logic spd_zero;
  assign spd_zero = (rd_data[SPD_LSB +: SPD_W] == '0);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!mdc && !mdc_rise && !mdc_fall && !mdc_running && rd_data == '0));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[0] == 1'b0);

  // R4
  stopped_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
    (spd_zero && !mdc) |=> (!mdc && !mdc_rise));

  // R6
  rise_marks_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> mdc_rise);

  // R6
  rise_only_high_chk: assert property (@(posedge clk) disable iff (rst)
    mdc_rise |-> mdc);

  // R6
  fall_marks_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mdc) |-> mdc_fall);

  // R6
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mdc_rise, mdc_fall}));

  // R10
  running_covers_high_chk: assert property (@(posedge clk) disable iff (rst)
    mdc |-> mdc_running);
endmodule

bind mdc_clkgen mdc_clkgen_chk #(
  .DATA_W (DATA_W),
  .SPD_W  (SPD_W),
  .SPD_LSB(SPD_LSB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_data    (rd_data),
  .mdc        (mdc),
  .mdc_rise   (mdc_rise),
  .mdc_fall   (mdc_fall),
  .mdc_running(mdc_running)
);

// File: tb/sim_mdc_clkgen.sv
`timescale 1ns/1ps
module sim_mdc_clkgen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pre_skip, mdc, mdc_rise, mdc_fall, mdc_running;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mdc_clkgen u0 (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .pre_skip   (pre_skip),
    .mdc        (mdc),
    .mdc_rise   (mdc_rise),
    .mdc_fall   (mdc_fall),
    .mdc_running(mdc_running)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && (mdc || mdc_running); i++) @(negedge clk);
    @(negedge clk);
  endtask

  // Counts high cycles from a rise cycle, checks the fall strobe, counts low cycles.
  task automatic measure(input int n, input string tag);
    int h = 0;
    int l = 0;
    for (int i = 0; i < 300 && !mdc_rise; i++) @(negedge clk);
    check(mdc_rise && mdc, {tag, " rise strobe"}, mdc_rise, 1);
    while (mdc && h < 300) begin h++; @(negedge clk); end
    check(h == n, {tag, " high length"}, h, n);
    check(mdc_fall && !mdc_rise, {tag, " fall strobe"}, mdc_fall, 1);
    while (!mdc && l < 300) begin
      if (l > 0) check(!mdc_fall, {tag, " fall width"}, mdc_fall, 0);
      l++; @(negedge clk);
    end
    check(l == n, {tag, " low length"}, l, n);
    check(mdc_running, {tag, " running"}, mdc_running, 1);
  endtask

  task automatic t_reset();
    check(rd_data == 32'h0, "R1 readback", rd_data, 0);
    check(!mdc && !mdc_rise && !mdc_fall, "R1 mdc idle", {mdc, mdc_rise, mdc_fall}, 0);
    check(!mdc_running && !pre_skip, "R1 flags", {mdc_running, pre_skip}, 0);
  endtask

  task automatic t_readback();
    write_reg(32'hFFFF_FFFF);
    check(rd_data == 32'h0000_00FE, "R2 all ones", rd_data, 32'hFE);
    check(pre_skip == 1'b1, "R3 skip set", pre_skip, 1);
    write_reg(32'h0000_0081);
    check(rd_data == 32'h0000_0080, "R2 bit0 dropped", rd_data, 32'h80);
    check(pre_skip == 1'b1, "R3 skip kept", pre_skip, 1);
    wait_idle();
    write_reg(32'h1234_560A);
    check(rd_data == 32'h0000_000A, "R2 speed only", rd_data, 32'h0A);
    check(pre_skip == 1'b0, "R3 skip clear", pre_skip, 0);
    write_reg(32'h0);
    wait_idle();
  endtask

  task automatic t_stopped();
    int seen = 0;
    write_reg(32'h0000_0080);
    for (int i = 0; i < 40; i++) begin
      if (mdc || mdc_rise || mdc_fall || mdc_running) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R4 zero speed idle", seen, 0);
  endtask

  task automatic t_startup(input int n);
    write_reg(32'(n) << 1);
    check(!mdc, "R9 not yet high", mdc, 0);
    @(negedge clk);
    check(mdc && mdc_rise && mdc_running, "R9 first rise", {mdc, mdc_rise, mdc_running}, 3'b111);
  endtask

  task automatic t_period(input int n);
    t_startup(n);
    measure(n, $sformatf("R5 R6 R10 N=%0d", n));
    measure(n, $sformatf("R5 repeat N=%0d", n));
    write_reg(32'h0);
    wait_idle();
  endtask

  task automatic t_change();
    int h = 1;
    int l = 0;
    t_startup(4);
    wr_data = 32'(2) << 1;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    while (mdc && h < 300) begin h++; @(negedge clk); end
    check(h == 4, "R7 old high length kept", h, 4);
    while (!mdc && l < 300) begin l++; @(negedge clk); end
    check(l == 2, "R7 new low length", l, 2);
    measure(2, "R7 new period");
    write_reg(32'h0);
    wait_idle();
  endtask

  task automatic t_to_zero();
    int h = 1;
    int seen = 0;
    t_startup(3);
    wr_data = 32'h0;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    while (mdc && h < 300) begin h++; @(negedge clk); end
    check(h == 3, "R8 high phase completes", h, 3);
    check(mdc_fall && !mdc_running, "R8 fall and stop", {mdc_fall, mdc_running}, 2'b10);
    @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      if (mdc || mdc_rise || mdc_fall || mdc_running) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R8 stays low", seen, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_stopped();
    t_period(1);
    t_period(5);
    t_period(63);
    t_change();
    t_to_zero();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule